// File: doc/BRIEF.md
# Parallel Port Forward Byte Transmitter

This block sends bytes from the host to a printer-style peripheral over a standard compatibility-mode parallel interface. It takes one byte at a time through a valid/ready handshake. It turns the bidirectional data lines to output, waits for the peripheral to report that it is ready, puts the byte on the bus, waits a setup time and then pulses the active-low strobe. After the strobe it waits for the rising edge of the acknowledge line. When the byte completes it gives one `byte_done` pulse. When the byte fails it gives one `err` pulse. In both cases it goes back to accepting input.

The acknowledge line carries only a short pulse, so the block does not sample its level. It latches the rising edge into a flag. The flag is cleared just before each strobe, and it can only be set from the start of the strobe onward. If no edge arrives within the timeout and the peripheral still shows busy, the wait starts again, up to a set number of restarts. When `miss_ok` is high, the wait uses a shorter timeout. In that mode, a timeout with the peripheral idle, no fault and selected counts as a missed acknowledge, and the byte is treated as sent. All status inputs pass through a two-stage synchronizer before the block uses them. Every delay is a parameter counted in clock cycles.

Top module: `lpt_fwd_tx`

## Requirements
- R1: Out of reset `n_strobe` is 1, `pd_dir` is 1 (data lines released), `pd_o` is 0, `in_ready` is 1, and `byte_done` and `err` are 0.
- R2: Accepting a byte drives `pd_dir` to 0 (output) before the strobe. `pd_dir` then stays 0 until reset.
- R3: Before each byte the block waits until the peripheral is ready: `busy` low, `n_fault` high and `select` high. If that does not happen within READY_CYC cycles, it pulses `err` without strobing and returns to ready.
- R4: The byte appears on `pd_o` at least SETUP_CYC cycles before `n_strobe` falls, and it does not change while `n_strobe` is low.
- R5: Each byte that passes the ready wait gets exactly one `n_strobe` low pulse, lasting STROBE_CYC cycles.
- R6: A rising edge on `n_ack` seen after the strobe starts completes the byte with a one-cycle `byte_done` pulse.
- R7: The acknowledge window is ACK_CYC cycles when `miss_ok` is 0 and ACK_SHORT_CYC cycles when `miss_ok` is 1.
- R8: If the acknowledge window expires while `busy` is high, the window starts again. Once RETRY_MAX restarts have been used, the next such expiry pulses `err`.
- R9: If the window expires with `busy` low, the byte completes with `byte_done` only when `miss_ok` is 1 and both `n_fault` and `select` are high. Otherwise the block pulses `err`.
- R10: `in_ready` is 0 from the accepting cycle until the outcome pulse. Each accepted byte gives exactly one of `byte_done` or `err`, and never both in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Byte offered |
| in_data | input | 8 | Byte to send |
| in_ready | output | 1 | Block is idle and takes the offered byte |
| miss_ok | input | 1 | Enables the short window and the missed-acknowledge fallback |
| busy | input | 1 | Peripheral busy, active high |
| n_ack | input | 1 | Peripheral acknowledge, active low pulse |
| n_fault | input | 1 | Peripheral fault, active low |
| select | input | 1 | Peripheral selected/online, active high |
| pd_o | output | 8 | Data lines |
| pd_dir | output | 1 | Data direction, 1 = input/released, 0 = output |
| n_strobe | output | 1 | Data strobe, active low |
| byte_done | output | 1 | One-cycle pulse when a byte completes |
| err | output | 1 | One-cycle pulse when a byte fails |

## Verification
The peripheral model covers several cases, each with and without the fallback:
- A clean acknowledge pulse.
- A busy period that ends with no acknowledge.
- A busy period that outlasts several windows before the acknowledge.
- Busy that never clears.
- A fault raised during the window.

The clean pulse and the long busy period show that a latched edge completes the byte and that restarts are taken while busy is high. The silent busy period tells the fallback's early completion apart from the long-window error. The stuck and fault cases check that restarts run out and that the fallback refuses a faulted peripheral. The outcome latency measured for each case separates the two window lengths and the number of restarts used. Directed cases hold the peripheral busy before the strobe, once until the ready wait times out and once until it is released.

// File: rtl/lpt_fwd_tx.sv
module lpt_fwd_tx #(
  parameter int SETUP_CYC     = 250,
  parameter int STROBE_CYC    = 250,
  parameter int READY_CYC     = 250000,
  parameter int ACK_CYC       = 250000,
  parameter int ACK_SHORT_CYC = 2500,
  parameter int RETRY_MAX     = 10000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  output logic       in_ready,
  input  logic       miss_ok,
  input  logic       busy,
  input  logic       n_ack,
  input  logic       n_fault,
  input  logic       select,
  output logic [7:0] pd_o,
  output logic       pd_dir,
  output logic       n_strobe,
  output logic       byte_done,
  output logic       err
);

  localparam int M1   = SETUP_CYC > STROBE_CYC ? SETUP_CYC : STROBE_CYC;
  localparam int M2   = READY_CYC > ACK_CYC ? READY_CYC : ACK_CYC;
  localparam int M3   = M1 > M2 ? M1 : M2;
  localparam int CMAX = M3 > ACK_SHORT_CYC ? M3 : ACK_SHORT_CYC;
  localparam int CW   = $clog2(CMAX + 1);
  localparam int RW   = $clog2(RETRY_MAX + 1);

  typedef enum logic [2:0] {S_IDLE, S_RDY, S_SETUP, S_STRB, S_ACK} state_t;

  state_t        state;
  logic [CW-1:0] cnt;
  logic [RW-1:0] retry;
  logic [7:0]    hold;
  logic [3:0]    s1, s2;
  logic          ack_q, ack_flag;

  wire busy_s = s2[3];
  wire ack_s  = s2[2];
  wire flt_s  = s2[1];
  wire sel_s  = s2[0];

  wire           ack_rise  = ack_s & ~ack_q;
  wire           periph_ok = ~busy_s & flt_s & sel_s;
  wire [CW-1:0]  ack_last  = miss_ok ? CW'(ACK_SHORT_CYC - 1) : CW'(ACK_CYC - 1);
  wire           setup_end = (state == S_SETUP) && (cnt == CW'(SETUP_CYC - 1));

  assign in_ready = (state == S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1    <= 4'b0111;
      s2    <= 4'b0111;
      ack_q <= 1'b1;
    end else begin
      s1    <= {busy, n_ack, n_fault, select};
      s2    <= s1;
      ack_q <= ack_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ack_flag <= 1'b0;
    else if (setup_end)
      ack_flag <= 1'b0;
    else if (ack_rise && (state == S_STRB || state == S_ACK))
      ack_flag <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      cnt       <= '0;
      retry     <= '0;
      hold      <= '0;
      pd_o      <= '0;
      pd_dir    <= 1'b1;
      n_strobe  <= 1'b1;
      byte_done <= 1'b0;
      err       <= 1'b0;
    end else begin
      byte_done <= 1'b0;
      err       <= 1'b0;
      case (state)
        S_IDLE: if (in_valid) begin
          hold   <= in_data;
          pd_dir <= 1'b0;
          cnt    <= '0;
          state  <= S_RDY;
        end
        S_RDY: begin
          if (periph_ok) begin
            pd_o  <= hold;
            cnt   <= '0;
            state <= S_SETUP;
          end else if (cnt == CW'(READY_CYC - 1)) begin
            err   <= 1'b1;
            state <= S_IDLE;
          end else
            cnt <= cnt + 1'b1;
        end
        S_SETUP: begin
          if (setup_end) begin
            n_strobe <= 1'b0;
            cnt      <= '0;
            state    <= S_STRB;
          end else
            cnt <= cnt + 1'b1;
        end
        S_STRB: begin
          if (cnt == CW'(STROBE_CYC - 1)) begin
            n_strobe <= 1'b1;
            cnt      <= '0;
            retry    <= '0;
            state    <= S_ACK;
          end else
            cnt <= cnt + 1'b1;
        end
        S_ACK: begin
          if (ack_flag) begin
            byte_done <= 1'b1;
            state     <= S_IDLE;
          end else if (cnt == ack_last) begin
            cnt <= '0;
            if (busy_s) begin
              if (retry == RW'(RETRY_MAX)) begin
                err   <= 1'b1;
                state <= S_IDLE;
              end else
                retry <= retry + 1'b1;
            end else if (miss_ok && flt_s && sel_s) begin
              byte_done <= 1'b1;
              state     <= S_IDLE;
            end else begin
              err   <= 1'b1;
              state <= S_IDLE;
            end
          end else
            cnt <= cnt + 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  a_r2_strobe_needs_output: assert property (@(posedge clk) disable iff (!rst_n)
    !n_strobe |-> !pd_dir);
  a_r2_dir_stays_output: assert property (@(posedge clk) disable iff (!rst_n)
    !pd_dir |=> !pd_dir);
  a_r4_data_stable_in_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (!n_strobe && !$past(n_strobe)) |-> $stable(pd_o));
  a_r10_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    !(byte_done && err));
  a_r10_not_ready_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
    !n_strobe |-> !in_ready);
  a_r6_done_returns_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done || err) |-> in_ready);

endmodule

// File: tb/lpt_fwd_tx_tb_top.sv
module lpt_fwd_tx_tb_top;
  localparam int SETUP = 3, STRB = 4, RDY = 20, ACK = 40, ACKS = 12, RETRY = 3;
  localparam logic [2:0] M_NORM = 0, M_MISS = 1, M_LONG = 2, M_STUCK = 3, M_FAULT = 4;
  // {data, mode, miss_ok, expect_done}
  localparam int NV = 9;
  localparam logic [12:0] VEC [NV] = '{
    {8'hA5, M_NORM,  1'b0, 1'b1},
    {8'h3C, M_NORM,  1'b1, 1'b1},
    {8'h00, M_MISS,  1'b1, 1'b1},
    {8'hFF, M_MISS,  1'b0, 1'b0},
    {8'h81, M_LONG,  1'b1, 1'b1},
    {8'h7E, M_LONG,  1'b0, 1'b1},
    {8'h55, M_STUCK, 1'b1, 1'b0},
    {8'hAA, M_FAULT, 1'b1, 1'b0},
    {8'h12, M_STUCK, 1'b0, 1'b0}
  };

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, miss_ok = 0;
  logic [7:0] in_data = 0;
  logic busy = 0, n_ack = 1, n_fault = 1, select = 1;
  logic in_ready, pd_dir, n_strobe, byte_done, err;
  logic [7:0] pd_o;

  int checks = 0, fails = 0;
  logic [2:0] pmode = M_NORM;
  bit force_busy = 0, stop_req = 0, active = 0, prev_strb = 1;
  int pcnt = 0, low_run = 0, last_width = 0, pulse_cnt = 0, stable_run = 0, setup_seen = 0;
  logic [7:0] got_byte = 0, prev_pd = 0;

  always #2 clk = ~clk;

  lpt_fwd_tx #(.SETUP_CYC(SETUP), .STROBE_CYC(STRB), .READY_CYC(RDY), .ACK_CYC(ACK),
               .ACK_SHORT_CYC(ACKS), .RETRY_MAX(RETRY)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .miss_ok(miss_ok), .busy(busy), .n_ack(n_ack), .n_fault(n_fault), .select(select),
    .pd_o(pd_o), .pd_dir(pd_dir), .n_strobe(n_strobe), .byte_done(byte_done), .err(err));

  // peripheral model and bus monitor
  always @(negedge clk) begin
    if (prev_strb && !n_strobe) begin
      got_byte = pd_o; setup_seen = stable_run; pulse_cnt++;
      active = 1; pcnt = 0; low_run = 1;
    end else if (!n_strobe) low_run++;
    if (!prev_strb && n_strobe) last_width = low_run;
    if (pd_o != prev_pd) stable_run = 1; else stable_run++;
    prev_pd = pd_o; prev_strb = n_strobe;
    if (stop_req) begin
      active = 0; n_ack = 1; n_fault = 1;
    end
    if (active) begin
      pcnt++;
      busy = 1;
      case (pmode)
        M_NORM: begin
          if (pcnt == 5) n_ack = 0;
          if (pcnt == 8) begin n_ack = 1; active = 0; end
        end
        M_MISS: if (pcnt == 6) active = 0;
        M_LONG: begin
          if (pcnt == 27) n_ack = 0;
          if (pcnt == 30) begin n_ack = 1; active = 0; end
        end
        M_FAULT: begin
          n_fault = 0;
          if (pcnt >= 6) busy = 0;
          if (pcnt == 20) begin n_fault = 1; active = 0; end
        end
        default: ;
      endcase
    end
    if (!active) busy = force_busy;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] d);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1; in_data = d;
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic outcome(output int got, output int lat, output bit rdy_mid);
    got = -1; lat = 0; rdy_mid = 1;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      lat++;
      if (lat == 3) rdy_mid = in_ready;
      if (byte_done) begin got = 1; break; end
      if (err) begin got = 0; break; end
    end
  endtask

  task automatic settle();
    @(negedge clk); stop_req = 1;
    @(negedge clk); stop_req = 0;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int got, lat, pc0;
    bit rm;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(n_strobe == 1, "R1 n_strobe", n_strobe, 1);
    chk(pd_dir == 1, "R1 pd_dir", pd_dir, 1);
    chk(in_ready == 1 && byte_done == 0 && err == 0 && pd_o == 0, "R1 idle outputs",
        {in_ready, byte_done, err}, 3'b100);
    rst_n = 1;
    repeat (3) @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      logic [7:0] d; logic [2:0] m; logic mo, ed;
      {d, m, mo, ed} = VEC[v];
      pmode = m; miss_ok = mo;
      pc0 = pulse_cnt;
      send(d);
      outcome(got, lat, rm);
      chk(got == int'(ed), $sformatf("R6 R8 R9 outcome v%0d", v), got, int'(ed));
      chk(rm == 0, $sformatf("R10 ready low in flight v%0d", v), rm, 0);
      chk(pd_dir == 0, $sformatf("R2 dir output v%0d", v), pd_dir, 0);
      chk(got_byte == d, $sformatf("R4 byte on bus v%0d", v), got_byte, d);
      chk(setup_seen >= SETUP, $sformatf("R4 setup v%0d", v), setup_seen, SETUP);
      chk(pulse_cnt == pc0 + 1, $sformatf("R5 one strobe v%0d", v), pulse_cnt - pc0, 1);
      chk(last_width == STRB, $sformatf("R5 strobe width v%0d", v), last_width, STRB);
      if (v == 2) chk(lat < 30, "R7 short window", lat, 20);
      if (v == 3) chk(lat > 40, "R7 long window", lat, 48);
      if (v == 6) chk(lat >= 50 && lat <= 62, "R8 restarts short", lat, 56);
      if (v == 8) chk(lat >= 160 && lat <= 175, "R8 restarts long", lat, 168);
      settle();
    end

    // R3 ready timeout: no strobe, error
    pmode = M_NORM; miss_ok = 0; force_busy = 1;
    repeat (3) @(negedge clk);
    pc0 = pulse_cnt;
    send(8'h69);
    outcome(got, lat, rm);
    chk(got == 0, "R3 ready timeout err", got, 0);
    chk(lat >= 18 && lat <= 26, "R3 ready timeout latency", lat, 20);
    chk(pulse_cnt == pc0, "R3 no strobe on timeout", pulse_cnt - pc0, 0);
    chk(in_ready == 1, "R10 ready after err", in_ready, 1);

    // R3 wait then proceed once released
    send(8'hC3);
    repeat (10) @(negedge clk);
    chk(pulse_cnt == pc0, "R3 held while busy", pulse_cnt - pc0, 0);
    force_busy = 0;
    outcome(got, lat, rm);
    chk(got == 1, "R3 proceeds after ready", got, 1);
    chk(got_byte == 8'hC3, "R4 byte after ready wait", got_byte, 8'hC3);
    settle();

    // R6 back-to-back bytes
    pc0 = pulse_cnt;
    for (int k = 0; k < 3; k++) begin
      send(8'(8'h10 + k));
      outcome(got, lat, rm);
      chk(got == 1 && got_byte == 8'(8'h10 + k), "R6 back-to-back", got_byte, 8'h10 + k);
    end
    chk(pulse_cnt == pc0 + 3, "R5 pulses per byte", pulse_cnt - pc0, 3);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule